// File: doc/BRIEF.md
# Segment Ownership Access Checker

This block sits between a requester (instruction fetch or a load/store unit) and a small byte-wide memory. The memory is split into equal segments, and an owner table holds one entry per segment: a valid bit and the ID of the virtual machine that owns it. Every access carries a byte address and the ID of the running VM. The block takes the segment number from the upper address bits, looks up the owner and compares it with the requesting VM. The memory read and the ownership lookup happen in the same cycle. The read data reaches the requester only when the check passes. A failed check raises a fault, blocks any write and returns zero.

The supervisor software manages ownership with two commands. An assign command gives a free segment to a VM. If the segment already has an owner, the command is refused and an error pulse is raised. A release command frees every segment owned by one VM in a single cycle. The block then overwrites each byte of those segments with zero, one byte per cycle. It holds a busy flag while it does this, and it stalls new accesses and commands until the scrub is done. VM ID 0 is the hypervisor, and it obtains segments through the same assign path as any other VM.

Top module: `seg_guard`

## Requirements
- R1: After reset no segment has an owner, `busy` is 0, `acc_ready` is 1 and `rsp_valid` is 0, so any access faults until a segment is assigned.
- R2: The segment of an access is address bits [7:4], so each segment spans 16 consecutive bytes. Segment 2 covers 0x20 to 0x2F.
- R3: A read by the owning VM returns the stored byte on `rsp_rdata`, with `rsp_valid`=1 and `rsp_fault`=0, in the cycle after the access is accepted.
- R4: An access to an unowned segment, or to a segment owned by a different VM, sets `rsp_valid` and `rsp_fault` for that one response with `rsp_rdata`=0, and leaves memory unchanged.
- R5: A write by the owning VM stores `acc_wdata` at `acc_addr`. Its response carries `rsp_fault`=0 and `rsp_rdata`=0.
- R6: An assign to an unowned segment records the VM as owner. An assign to an owned segment leaves the owner unchanged and pulses `asg_err` for one cycle, in the cycle after the command.
- R7: A release marks every segment owned by `rel_vmid` as unowned. Segments of other VMs keep their owners, and a freed segment can be assigned again without error.
- R8: After a release, each byte of each freed segment is written with zero, one byte per cycle. `busy` is high for exactly 16 cycles per freed segment, starting the cycle after the release, and stays low if the VM owned nothing.
- R9: While `busy` is high, `acc_ready` is 0 and accesses, assigns and releases are ignored: no response, no memory or table change, no error.
- R10: When a release and an assign arrive in the same cycle, the release is performed and the assign is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request |
| acc_write | input | 1 | 1 = store, 0 = load or fetch |
| acc_addr | input | 8 | Byte address |
| acc_wdata | input | 8 | Store data |
| acc_vmid | input | 4 | ID of the running VM |
| acc_ready | output | 1 | Access is accepted this cycle (not busy) |
| rsp_valid | output | 1 | Response strobe, one cycle after acceptance |
| rsp_fault | output | 1 | Ownership check failed |
| rsp_rdata | output | 8 | Read data, zero on fault or store |
| asg_valid | input | 1 | Assign command |
| asg_seg | input | 4 | Segment to assign |
| asg_vmid | input | 4 | New owner |
| asg_err | output | 1 | Assign refused, segment already owned |
| rel_valid | input | 1 | Release command |
| rel_vmid | input | 4 | VM whose segments are freed |
| busy | output | 1 | Scrub in progress |

## Verification
Accesses are tried in four forms: by the owner, by another VM, to an unowned segment, and at the byte on each side of a segment boundary. Together these separate an owner compare from a valid-bit check, and they show whether the segment is taken from the right address bits. Each segment is written with a pattern that depends on its address, so a scrub that misses a byte, or one that reaches into a neighbouring segment of another VM, shows up in the later reads. Releases are issued for a VM with two segments and for a VM with none, which checks the busy length. An access and an assign are injected while the block is busy, and also a release and an assign in the same cycle. These show that stalled or dropped commands leave no trace.

// File: rtl/seg_guard.sv
module seg_guard #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SEG_W  = 4,
  parameter int VMID_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [VMID_W-1:0] acc_vmid,
  output logic              acc_ready,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              asg_valid,
  input  logic [SEG_W-1:0]  asg_seg,
  input  logic [VMID_W-1:0] asg_vmid,
  output logic              asg_err,
  input  logic              rel_valid,
  input  logic [VMID_W-1:0] rel_vmid,
  output logic              busy
);
  localparam int NSEG  = 1 << SEG_W;
  localparam int OFS_W = ADDR_W - SEG_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              own_v  [NSEG];
  logic [VMID_W-1:0] own_id [NSEG];
  logic [NSEG-1:0]   scrub_mask;
  logic [OFS_W-1:0]  scrub_ofs;
  logic [SEG_W-1:0]  cur_seg;

  logic [SEG_W-1:0] acc_seg;
  logic             take, hit;

  assign busy      = |scrub_mask;
  assign acc_ready = !busy;
  assign acc_seg   = acc_addr[ADDR_W-1 -: SEG_W];
  assign take      = acc_valid && !busy;
  assign hit       = own_v[acc_seg] && (own_id[acc_seg] == acc_vmid);

  always_comb begin
    cur_seg = '0;
    for (int i = NSEG - 1; i >= 0; i--)
      if (scrub_mask[i]) cur_seg = SEG_W'(i);
  end

  always_ff @(posedge clk) begin
    if (busy)
      mem[{cur_seg, scrub_ofs}] <= '0;
    else if (take && hit && acc_write)
      mem[acc_addr] <= acc_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= take;
      rsp_fault <= take && !hit;
      rsp_rdata <= (take && hit && !acc_write) ? mem[acc_addr] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) begin
        own_v[i]  <= 1'b0;
        own_id[i] <= '0;
      end
      scrub_mask <= '0;
      scrub_ofs  <= '0;
      asg_err    <= 1'b0;
    end else begin
      asg_err <= 1'b0;
      if (busy) begin
        scrub_ofs <= scrub_ofs + 1'b1;
        if (&scrub_ofs) scrub_mask[cur_seg] <= 1'b0;
      end else if (rel_valid) begin
        scrub_ofs <= '0;
        for (int i = 0; i < NSEG; i++)
          if (own_v[i] && own_id[i] == rel_vmid) begin
            own_v[i]      <= 1'b0;
            own_id[i]     <= '0;
            scrub_mask[i] <= 1'b1;
          end
      end else if (asg_valid) begin
        if (own_v[asg_seg]) asg_err <= 1'b1;
        else begin
          own_v[asg_seg]  <= 1'b1;
          own_id[asg_seg] <= asg_vmid;
        end
      end
    end
  end
endmodule

// File: rtl/seg_guard_chk.sv
module seg_guard_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_ready,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              asg_valid,
  input logic              asg_err,
  input logic              rel_valid,
  input logic              busy
);
  // R4
  fault_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_valid && rsp_rdata == '0));
  // R3
  rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(acc_valid && acc_ready));
  // R9
  busy_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !rsp_valid);
  // R6
  err_after_assign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asg_err |-> $past(asg_valid && !busy));
  // R8
  busy_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(rel_valid));
endmodule

bind seg_guard seg_guard_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/seg_guard_test.sv
module seg_guard_test;
  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0;
  logic [7:0] acc_addr = 0, acc_wdata = 0;
  logic [3:0] acc_vmid = 0;
  logic acc_ready, rsp_valid, rsp_fault, asg_err, busy;
  logic [7:0] rsp_rdata;
  logic asg_valid = 0, rel_valid = 0;
  logic [3:0] asg_seg = 0, asg_vmid = 0, rel_vmid = 0;

  int checks = 0, errors = 0;
  logic [7:0] mm [256];
  logic       mv [16];
  logic [3:0] mo [16];
  logic [8:0] expq [$];
  string      tagq [$];

  always #10 clk = ~clk;

  seg_guard uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && rsp_valid) begin
    if (expq.size() == 0) chk(0, "R9 unexpected response", 1, 0);
    else begin
      logic [8:0] e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      chk({rsp_fault, rsp_rdata} == e, t, {rsp_fault, rsp_rdata}, e);
    end
  end

  task automatic access(input bit w, input logic [7:0] a, input logic [7:0] d,
                        input logic [3:0] vm, input string tag);
    bit ok;
    while (busy) @(negedge clk);
    ok = mv[a[7:4]] && mo[a[7:4]] == vm;
    expq.push_back({!ok, (ok && !w) ? mm[a] : 8'h00});
    tagq.push_back(tag);
    if (ok && w) mm[a] = d;
    acc_valid = 1; acc_write = w; acc_addr = a; acc_wdata = d; acc_vmid = vm;
    @(negedge clk);
    acc_valid = 0;
  endtask

  task automatic assign_seg(input logic [3:0] s, input logic [3:0] vm);
    bit e;
    e = mv[s];
    if (!e) begin mv[s] = 1; mo[s] = vm; end
    asg_valid = 1; asg_seg = s; asg_vmid = vm;
    @(negedge clk);
    asg_valid = 0;
    chk(asg_err == e, "R6 asg_err", asg_err, e);
  endtask

  task automatic release_vm(input logic [3:0] vm, input bit inject);
    int n, cnt;
    n = 0;
    for (int s = 0; s < 16; s++)
      if (mv[s] && mo[s] == vm) begin
        n++; mv[s] = 0; mo[s] = 0;
        for (int o = 0; o < 16; o++) mm[s*16+o] = 0;
      end
    rel_valid = 1; rel_vmid = vm;
    @(negedge clk);
    rel_valid = 0;
    cnt = 0;
    if (inject) begin
      chk(acc_ready == 0, "R9 acc_ready while busy", acc_ready, 0);
      acc_valid = 1; acc_write = 1; acc_addr = 8'h51; acc_wdata = 8'hEE; acc_vmid = 2;
      asg_valid = 1; asg_seg = 9; asg_vmid = 4;
      rel_valid = 1; rel_vmid = 2;
      cnt++;
      @(negedge clk);
      acc_valid = 0; asg_valid = 0; rel_valid = 0;
      chk(asg_err == 0, "R9 no assign error while busy", asg_err, 0);
    end
    while (busy && cnt < 1000) begin cnt++; @(negedge clk); end
    chk(cnt == 16 * n, "R8 busy length", cnt, 16 * n);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mm[i] = 0;
    for (int i = 0; i < 16; i++) begin mv[i] = 0; mo[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0, "R1 busy after reset", busy, 0);
    chk(acc_ready == 1, "R1 ready after reset", acc_ready, 1);
    chk(rsp_valid == 0, "R1 no response after reset", rsp_valid, 0);
    access(0, 8'h30, 0, 0, "R1 unowned after reset");

    assign_seg(2, 1); assign_seg(5, 2); assign_seg(6, 1); assign_seg(0, 0);
    for (int o = 0; o < 16; o++) begin
      access(1, 8'h20 + 8'(o), 8'h20 + 8'(o) ^ 8'hA5, 1, "R5 write vm1");
      access(1, 8'h50 + 8'(o), 8'h50 + 8'(o) ^ 8'h3C, 2, "R5 write vm2");
      access(1, 8'h60 + 8'(o), 8'h60 + 8'(o) ^ 8'h5A, 1, "R5 write vm1 seg6");
      access(1, 8'h00 + 8'(o), 8'(o) ^ 8'hC3, 0, "R5 write hypervisor");
    end
    access(0, 8'h27, 0, 1, "R3 owner read");
    access(0, 8'h5F, 0, 2, "R3 owner read vm2");
    access(0, 8'h0B, 0, 0, "R3 hypervisor read");
    access(1, 8'h23, 8'hFF, 2, "R4 foreign write");
    access(0, 8'h23, 0, 1, "R4 foreign write blocked");
    access(0, 8'h05, 0, 1, "R4 vm1 on hypervisor segment");
    access(0, 8'h1F, 0, 1, "R2 byte below boundary");
    access(0, 8'h20, 0, 1, "R2 first byte of segment");
    access(0, 8'h2F, 0, 1, "R2 last byte of segment");
    access(0, 8'h30, 0, 1, "R2 byte above boundary");

    assign_seg(2, 3);
    access(0, 8'h21, 0, 1, "R6 owner kept");
    access(0, 8'h21, 0, 3, "R6 refused vm faults");

    release_vm(1, 1);
    access(0, 8'h51, 0, 2, "R9 stalled write left no trace");
    access(0, 8'h25, 0, 1, "R7 released owner faults");
    access(0, 8'h65, 0, 1, "R7 released owner faults seg6");
    access(0, 8'h5A, 0, 2, "R7 other vm keeps segment");
    access(0, 8'h07, 0, 0, "R7 hypervisor keeps segment");
    assign_seg(9, 5);
    access(1, 8'h93, 8'h77, 5, "R9 stalled assign ignored");
    access(0, 8'h93, 0, 5, "R9 segment assigned after stall");
    assign_seg(2, 2); assign_seg(6, 3);
    for (int o = 0; o < 16; o++) begin
      access(0, 8'h20 + 8'(o), 0, 2, "R8 scrubbed byte seg2");
      access(0, 8'h60 + 8'(o), 0, 3, "R8 scrubbed byte seg6");
    end
    release_vm(7, 0);

    // R10: release of vm5 and assign of seg10 in the same cycle
    mv[9] = 0; mo[9] = 0;
    for (int o = 0; o < 16; o++) mm[144 + o] = 0;
    rel_valid = 1; rel_vmid = 5; asg_valid = 1; asg_seg = 10; asg_vmid = 6;
    @(negedge clk);
    rel_valid = 0; asg_valid = 0;
    chk(busy == 1, "R10 release performed", busy, 1);
    while (busy) @(negedge clk);
    access(0, 8'hA0, 0, 6, "R10 assign dropped");
    access(0, 8'h93, 0, 5, "R10 released vm faults");

    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R3 all responses seen", expq.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule